// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns a burst request into the column address for every beat of that burst. A request carries a starting column, a burst-length code and an ordering bit. The block then presents one column per clock until the burst is done and marks the final beat. The memory controller that issues the read and write commands uses these columns. Data movement and command timing are handled elsewhere.

Bounded bursts of 1, 2, 4 or 8 beats stay inside the aligned block that holds the starting column. In sequential order the offset counts up and wraps back to the start of that block. In interleaved order the offset is the start offset XOR the beat number. A full-page burst counts through the whole 256-column row, wraps from 255 to 0, and runs until a terminate strobe arrives. A request with a setting that is not supported starts nothing and raises a one-cycle error pulse.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `valid_o`, `last_o` and `cfg_err_o` are low.
- R2: A legal request (`start_i` high at a clock edge) makes `valid_o` high from the next cycle, with `col_o` equal to the requested column in that cycle. One beat follows per cycle, with no gaps.
- R3: Length codes are 000=1, 001=2, 010=4 and 011=8 beats. With `ilv_i`=0 (sequential), beat i shows column `(start & ~(L-1)) | ((start + i) mod L)`. The bits above the block never change during the burst.
- R4: With `ilv_i`=1 (interleaved, codes 010 and 011 only), beat i shows the start column with its low log2(L) bits XOR i. For example, 8 beats starting at offset 2 give offsets 2,3,0,1,6,7,4,5.
- R5: Length code 000 gives exactly one beat, at the requested column, with `last_o` high.
- R6: In a bounded burst, `last_o` is high only on beat L-1, and `valid_o` is low in the next cycle unless a new burst was started. `term_i` has no effect on a bounded burst or when idle.
- R7: Length code 111 with `ilv_i`=0 is a full-page burst. The column rises by one per beat modulo 256 and runs without limit. In a cycle where `term_i` is high during such a burst, `last_o` is high, and `valid_o` is low in the next cycle.
- R8: Length codes 100, 101 and 110, and `ilv_i`=1 with codes 000, 001 or 111, are illegal. Such a request starts nothing and leaves a running burst untouched. It makes `cfg_err_o` high for exactly the next cycle.
- R9: A legal request that arrives while a burst is running abandons the running burst. The new burst starts in the next cycle, at its own beat 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe |
| start_col_i | input | 8 | Starting column of the request |
| len_code_i | input | 3 | Burst-length code |
| ilv_i | input | 1 | Ordering: 0 sequential, 1 interleaved |
| term_i | input | 1 | Ends a full-page burst |
| col_o | output | 8 | Column of the current beat (zero when idle) |
| valid_o | output | 1 | A beat is presented this cycle |
| last_o | output | 1 | This beat is the final one |
| cfg_err_o | output | 1 | The previous request had an illegal setting |

## Verification
Two situations are the hardest to reach. The first is a full-page burst that crosses from column 255 back to 0. The stimulus starts a page burst near the top of the row and holds it for more than 256 beats before terminating it. The second is an illegal request that arrives in the middle of a running burst, which must leave that burst untouched. The bench aims such requests at live bursts, both directly and in a random phase. That random phase also mixes restarts, stray terminate strobes and every length and order code.

// File: rtl/sbcg_pkg.sv
package sbcg_pkg;

  localparam int LG_W = 2;

  typedef enum logic [2:0] {
    LEN_1    = 3'b000,
    LEN_2    = 3'b001,
    LEN_4    = 3'b010,
    LEN_8    = 3'b011,
    LEN_PAGE = 3'b111
  } len_code_e;

  typedef struct packed {
    logic            page;
    logic            ilv;
    logic [LG_W-1:0] lg;
  } burst_cfg_t;

endpackage

// File: rtl/sbcg_decode.sv
module sbcg_decode
  import sbcg_pkg::*;
(
  input  logic [2:0] len_code_i,
  input  logic       ilv_i,
  output burst_cfg_t cfg_o,
  output logic       legal_o
);

  always_comb begin
    cfg_o     = '0;
    cfg_o.ilv = ilv_i;
    legal_o   = 1'b1;
    case (len_code_e'(len_code_i))
      LEN_1, LEN_2, LEN_4, LEN_8: cfg_o.lg = len_code_i[LG_W-1:0];
      LEN_PAGE:                   cfg_o.page = 1'b1;
      default:                    legal_o = 1'b0;
    endcase
    // interleave only defined for 4 and 8 beats
    if (ilv_i && (cfg_o.page || (cfg_o.lg < 2'd2)))
      legal_o = 1'b0;
  end

endmodule

// File: rtl/sbcg_seq.sv
module sbcg_seq
  import sbcg_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             legal_i,
  input  burst_cfg_t       cfg_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             term_i,
  input  logic [COL_W-1:0] mask_i,
  output logic             active_o,
  output burst_cfg_t       cfg_o,
  output logic [COL_W-1:0] base_o,
  output logic [COL_W-1:0] beat_o,
  output logic             final_o,
  output logic             err_o
);

  logic             active_q, active_d;
  burst_cfg_t       cfg_q, cfg_d;
  logic [COL_W-1:0] base_q, base_d;
  logic [COL_W-1:0] beat_q, beat_d;
  logic             err_q, err_d;
  logic             load;
  logic             en;
  logic             final_beat;

  assign final_beat = cfg_q.page ? term_i : (beat_q == mask_i);
  assign load       = start_i & legal_i;
  assign en         = load | active_q;

  always_comb begin
    active_d = active_q;
    cfg_d    = cfg_q;
    base_d   = base_q;
    beat_d   = beat_q;
    err_d    = start_i & ~legal_i;
    if (load) begin
      active_d = 1'b1;
      cfg_d    = cfg_i;
      base_d   = col_i;
      beat_d   = '0;
    end else if (active_q) begin
      if (final_beat) active_d = 1'b0;
      else            beat_d   = beat_q + COL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cfg_q    <= '0;
      base_q   <= '0;
      beat_q   <= '0;
    end else if (en) begin
      active_q <= active_d;
      cfg_q    <= cfg_d;
      base_q   <= base_d;
      beat_q   <= beat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign active_o = active_q;
  assign cfg_o    = cfg_q;
  assign base_o   = base_q;
  assign beat_o   = beat_q;
  assign final_o  = active_q & final_beat;
  assign err_o    = err_q;

  AST_BEAT_IN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !cfg_q.page) |-> ((beat_q & ~mask_i) == '0)) else $error("beat beyond block"); // R3

  AST_BOUNDED_END: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !cfg_q.page && final_beat && !start_i) |=> !active_q) else $error("burst ran on"); // R6

  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> ($past(start_i) && !$past(legal_i))) else $error("spurious error"); // R8

endmodule

// File: rtl/sbcg_addr.sv
module sbcg_addr
  import sbcg_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  burst_cfg_t       cfg_i,
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  output logic [COL_W-1:0] mask_o,
  output logic [COL_W-1:0] col_o
);

  logic [COL_W-1:0] len_onehot;
  logic [COL_W-1:0] low;

  assign len_onehot = COL_W'(1) << cfg_i.lg;
  assign mask_o     = cfg_i.page ? '1 : (len_onehot - COL_W'(1));
  assign low        = cfg_i.ilv ? (base_i ^ beat_i) : (base_i + beat_i);
  assign col_o      = (base_i & ~mask_o) | (low & mask_o);

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import sbcg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [7:0] start_col_i,
  input  logic [2:0] len_code_i,
  input  logic       ilv_i,
  input  logic       term_i,
  output logic [7:0] col_o,
  output logic       valid_o,
  output logic       last_o,
  output logic       cfg_err_o
);

  localparam int COL_W = 8;

  burst_cfg_t       req_cfg;
  logic             req_legal;
  burst_cfg_t       cur_cfg;
  logic             active;
  logic [COL_W-1:0] base;
  logic [COL_W-1:0] beat;
  logic [COL_W-1:0] mask;
  logic [COL_W-1:0] col;
  logic             fin;
  logic             err;

  sbcg_decode i_decode (
    .len_code_i (len_code_i),
    .ilv_i      (ilv_i),
    .cfg_o      (req_cfg),
    .legal_o    (req_legal)
  );

  sbcg_seq #(.COL_W(COL_W)) i_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .legal_i  (req_legal),
    .cfg_i    (req_cfg),
    .col_i    (start_col_i),
    .term_i   (term_i),
    .mask_i   (mask),
    .active_o (active),
    .cfg_o    (cur_cfg),
    .base_o   (base),
    .beat_o   (beat),
    .final_o  (fin),
    .err_o    (err)
  );

  sbcg_addr #(.COL_W(COL_W)) i_addr (
    .cfg_i  (cur_cfg),
    .base_i (base),
    .beat_i (beat),
    .mask_o (mask),
    .col_o  (col)
  );

  assign col_o     = active ? col : '0;
  assign valid_o   = active;
  assign last_o    = fin;
  assign cfg_err_o = err;

  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o) else $error("last without beat"); // R6

  AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && req_legal) |=> (valid_o && col_o == $past(start_col_i))) else $error("bad first beat"); // R2

  AST_PAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && cur_cfg.page && !last_o && !start_i) |=> (col_o == COL_W'($past(col_o) + 1'b1)))
    else $error("page step"); // R7

  AST_BLOCK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !cur_cfg.page && !last_o && !start_i) |=> ((col_o & ~mask) == $past(col_o & ~mask)))
    else $error("left block"); // R3

endmodule

// File: tb/test_sdram_burst_colgen.sv
module test_sdram_burst_colgen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] start_col_i = '0;
  logic [2:0] len_code_i = '0;
  logic       ilv_i = 1'b0;
  logic       term_i = 1'b0;
  logic [7:0] col_o;
  logic       valid_o, last_o, cfg_err_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit done    = 0;

  // behavioural reference state
  int m_act = 0, m_beat = 0, m_start = 0, m_len = 0, m_ilv = 0, m_err = 0, m_restart = 0;
  int m_first = 1;

  always #2 clk = ~clk;

  sdram_burst_colgen i_sdram_burst_colgen (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .len_code_i(len_code_i), .ilv_i(ilv_i), .term_i(term_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o), .cfg_err_o(cfg_err_o)
  );

  function automatic bit is_legal(int code, int il);
    if (code == 4 || code == 5 || code == 6) return 0;
    if (il != 0 && !(code == 2 || code == 3)) return 0;
    return 1;
  endfunction

  function automatic int exp_col();
    int base, off, o;
    if (m_len == 0) return (m_start + m_beat) % 256;
    off  = m_start % m_len;
    base = m_start - off;
    o    = (m_ilv != 0) ? (off ^ m_beat) : ((off + m_beat) % m_len);
    return base + o;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 0; m_beat = 0; m_err = 0; m_restart = 0; m_first = 1;
    end else begin
      m_first = 0;
      m_err = (start_i && !is_legal(len_code_i, ilv_i)) ? 1 : 0;
      if (start_i && is_legal(len_code_i, ilv_i)) begin
        m_restart = m_act;
        m_act = 1; m_beat = 0; m_start = start_col_i; m_ilv = ilv_i;
        m_len = (len_code_i == 3'd7) ? 0 : (1 << len_code_i);
      end else if (m_act != 0) begin
        if ((m_len != 0 && m_beat == m_len - 1) || (m_len == 0 && term_i)) m_act = 0;
        else m_beat = (m_beat + 1) % 256;
        m_restart = 0;
      end
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (!done) begin
      if (!rst_n || m_first != 0) begin
        check(!valid_o && !last_o && !cfg_err_o, "R1",
              {valid_o, last_o, cfg_err_o}, 0);
      end else begin
        int e_last;
        string rq;
        e_last = (m_act != 0) && ((m_len != 0 && m_beat == m_len - 1) || (m_len == 0 && term_i));
        check(cfg_err_o == m_err[0], "R8", cfg_err_o, m_err);
        check(valid_o == m_act[0], m_restart != 0 ? "R9" : "R2", valid_o, m_act);
        if (m_act != 0) begin
          if (m_restart != 0)      rq = "R9";
          else if (m_len == 0)     rq = "R7";
          else if (m_len == 1)     rq = "R5";
          else if (m_ilv != 0)     rq = "R4";
          else                     rq = "R3";
          check(col_o == exp_col(), rq, col_o, exp_col());
        end
        check(last_o == e_last[0], (m_len == 0) ? "R7" : "R6", last_o, e_last);
      end
    end
  end

  task automatic drive(bit s, int c, int code, bit il, bit t);
    @(negedge clk);
    start_i = s; start_col_i = 8'(c); len_code_i = 3'(code); ilv_i = il; term_i = t;
  endtask

  task automatic idle(int n, bit t = 0);
    for (int k = 0; k < n; k++) drive(0, 0, 0, 0, t);
  endtask

  task automatic finish_run();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected below 100000", cycles);
      finish_run();
    end
  end

  initial begin
    idle(3);                       // R1 during reset
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    drive(1, 8'h37, 0, 0, 0); idle(3);            // R5 single beat
    drive(1, 8'h45, 1, 0, 0); idle(3);            // R3 len 2 wrap
    drive(1, 8'h1E, 2, 0, 0); idle(5);            // R3 len 4 wrap
    drive(1, 8'hA5, 3, 0, 0); idle(9);            // R3 len 8
    drive(1, 8'h13, 2, 1, 0); idle(5);            // R4 interleave 4
    drive(1, 8'h02, 3, 1, 0); idle(9);            // R4 2-3-0-1-6-7-4-5
    drive(1, 8'h05, 3, 1, 0); idle(9);            // R4 5-4-7-6-1-0-3-2
    drive(1, 8'h6A, 3, 0, 1); idle(9, 1); idle(2);// R6 term ignored when bounded/idle
    drive(1, 8'hFA, 7, 0, 0); idle(300);          // R7 page crosses 255->0
    drive(0, 0, 0, 0, 1); idle(3);                // R7 terminate
    drive(1, 8'h10, 4, 0, 0); idle(2);            // R8 reserved code
    drive(1, 8'h10, 0, 1, 0); idle(2);            // R8 interleave len 1
    drive(1, 8'h10, 7, 1, 0); idle(2);            // R8 interleave page
    drive(1, 8'h80, 3, 0, 0); idle(2);
    drive(1, 8'h20, 6, 0, 0); idle(8);            // R8 illegal mid burst
    drive(1, 8'h40, 3, 0, 0); idle(3);
    drive(1, 8'hC3, 2, 1, 0); idle(6);            // R9 restart
    drive(1, 8'h77, 7, 0, 0); idle(5);
    drive(1, 8'h09, 1, 0, 0); idle(4);            // R9 page replaced
    for (int k = 0; k < 3000; k++)
      drive(($urandom % 5) == 0, $urandom % 256, $urandom % 8, ($urandom % 3) == 0,
            ($urandom % 6) == 0);
    idle(10, 1);
    idle(5);
    finish_run();
  end

endmodule